// File: doc/BRIEF.md
# I/O Range Forwarding Decoder

This block decides, for each I/O request seen on the processor side, whether the request is passed to the PCI side or left unclaimed. Software sets up two I/O window registers. Each window has a 16-bit lower bound, a 16-bit inclusive upper bound and an enable bit. Software also sets a single switch that turns on ISA alias folding. A request that falls inside an enabled window is forwarded, and the block reports which window claimed it. Every other request is ignored.

With alias folding on, the block first squeezes the address into the ISA card window (100h to 3FFh) and only then compares it against the windows. An address is folded when its bits 15:10 are non-zero and its bits 9:8 are not both zero. Folding clears bits 15:10 and keeps bits 9:0. All other addresses are compared unchanged. The decision comes out of a register one clock after the request strobe.

Top module: `io_range_fwd`

## Requirements
- R1: During and after synchronous reset, `dec_valid` and `dec_forward` are 0, both windows are disabled and alias folding is off.
- R2: `dec_valid` equals `req_valid` delayed by one clock. When `dec_valid` is 0, `dec_forward` is 0.
- R3: A window matches when lower ≤ address ≤ upper, with both bounds included. A request that matches an enabled window gives `dec_forward`=1, and `dec_range` (0 or 1) names that window.
- R4: A disabled window never claims a request, even when the address lies inside its bounds.
- R5: A request that matches no enabled window gives `dec_forward`=0 and `dec_range`=0.
- R6: When both windows match, `dec_range` reports window 0.
- R7: With folding on, an address whose bits 15:10 are non-zero and whose bits 9:8 are not both zero is compared as {6'b0, addr[9:0]}.
- R8: With folding on, an address whose bits 15:10 are zero, or whose bits 9:8 are both zero, is compared unchanged.
- R9: With folding off, every address is compared unchanged.
- R10: A window write (`cfg_wr`, with `cfg_sel` picking the window) or a fold-switch write made in the same clock as a request takes effect only from the next request.
- R11: A window whose lower bound is above its upper bound matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alias_wr | input | 1 | Write strobe for the fold switch |
| alias_wdata | input | 1 | New fold switch value |
| cfg_wr | input | 1 | Window register write strobe |
| cfg_sel | input | 1 | Window to write (0 or 1) |
| cfg_lower | input | 16 | New lower bound |
| cfg_upper | input | 16 | New inclusive upper bound |
| cfg_enable | input | 1 | New window enable |
| req_valid | input | 1 | I/O request strobe |
| req_addr | input | 16 | I/O request address |
| dec_valid | output | 1 | Decision present (one clock after request) |
| dec_forward | output | 1 | 1 = forward to PCI, 0 = ignore |
| dec_range | output | 1 | Window that claimed the request |

## Verification
The bench probes each window one address below, at, at and one above its bounds. A decoder that uses strict comparisons would drop the exact bound addresses, and an off-by-one would claim a neighbour. It uses overlapping windows, an inverted window and a request issued in the same clock as a configuration write. A wrong priority order would name window 1, a wrap-around compare would claim through the inverted window, and a combinational configuration path would apply the write one request early. For folding it sends addresses with bits 9:8 both zero, addresses with bits 15:10 zero, and addresses below 100h, as well as addresses that must fold. It repeats the folding cases with the switch off, so a fold that is too broad, too narrow or always on changes which window claims the request.

// File: rtl/iofwd_pkg.sv
package iofwd_pkg;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned NUM_RANGES = 2;
    localparam int unsigned ISA_W      = 10;
    localparam int unsigned RIDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;

    typedef logic [ADDR_W-1:0] ioaddr_t;

    typedef struct packed {
        ioaddr_t lower;
        ioaddr_t upper;
        logic    enable;
    } io_window_t;

    typedef struct packed {
        logic              forward;
        logic [RIDX_W-1:0] idx;
    } io_decision_t;

    // Fold an expansion-card alias back into the ISA card window.
    function automatic ioaddr_t fold_isa(input ioaddr_t a);
        ioaddr_t r;
        r = a;
        if ((|a[ADDR_W-1:ISA_W]) && (|a[ISA_W-1:ISA_W-2]))
            r = {{(ADDR_W-ISA_W){1'b0}}, a[ISA_W-1:0]};
        return r;
    endfunction
endpackage

// File: rtl/iofwd_alias_fold.sv
module iofwd_alias_fold
    import iofwd_pkg::*;
(
    input  logic    fold_on,
    input  ioaddr_t addr_in,
    output ioaddr_t addr_out
);
    assign addr_out = fold_on ? fold_isa(addr_in) : addr_in;
endmodule

// File: rtl/iofwd_window_match.sv
module iofwd_window_match
    import iofwd_pkg::*;
(
    input  io_window_t win,
    input  ioaddr_t    addr,
    output logic       hit
);
    logic above_lower;
    logic below_upper;

    assign above_lower = (addr >= win.lower);
    assign below_upper = (addr <= win.upper);
    assign hit         = win.enable && above_lower && below_upper;
endmodule

// File: rtl/iofwd_cfg_bank.sv
module iofwd_cfg_bank
    import iofwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alias_wr,
    input  logic              alias_wdata,
    input  logic              cfg_wr,
    input  logic [RIDX_W-1:0] cfg_sel,
    input  io_window_t        cfg_wdata,
    output logic              fold_on,
    output io_window_t        win_q [NUM_RANGES]
);
    always_ff @(posedge clk) begin
        if (rst)           fold_on <= 1'b0;
        else if (alias_wr) fold_on <= alias_wdata;
    end

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst)
                win_q[g] <= '0;
            else if (cfg_wr && (cfg_sel == RIDX_W'(g)))
                win_q[g] <= cfg_wdata;
        end
    end
endmodule

// File: rtl/io_range_fwd.sv
module io_range_fwd
    import iofwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alias_wr,
    input  logic              alias_wdata,
    input  logic              cfg_wr,
    input  logic [RIDX_W-1:0] cfg_sel,
    input  logic [ADDR_W-1:0] cfg_lower,
    input  logic [ADDR_W-1:0] cfg_upper,
    input  logic              cfg_enable,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              dec_valid,
    output logic              dec_forward,
    output logic [RIDX_W-1:0] dec_range
);
    io_window_t             cfg_wdata;
    io_window_t             win_q [NUM_RANGES];
    logic                   fold_on;
    ioaddr_t                cmp_addr;
    logic [NUM_RANGES-1:0]  hit_vec;
    io_decision_t           dec_d;
    io_decision_t           dec_q;
    logic                   valid_q;

    assign cfg_wdata = '{lower: cfg_lower, upper: cfg_upper, enable: cfg_enable};

    iofwd_cfg_bank u_cfg (
        .clk         (clk),
        .rst         (rst),
        .alias_wr    (alias_wr),
        .alias_wdata (alias_wdata),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .fold_on     (fold_on),
        .win_q       (win_q)
    );

    iofwd_alias_fold u_fold (
        .fold_on  (fold_on),
        .addr_in  (req_addr),
        .addr_out (cmp_addr)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
        iofwd_window_match u_match (
            .win  (win_q[g]),
            .addr (cmp_addr),
            .hit  (hit_vec[g])
        );
    end

    // Lowest-numbered window wins.
    always_comb begin
        dec_d = '0;
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                dec_d.forward = 1'b1;
                dec_d.idx     = RIDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dec_q   <= '0;
        end else begin
            valid_q <= req_valid;
            dec_q   <= req_valid ? dec_d : '0;
        end
    end

    assign dec_valid   = valid_q;
    assign dec_forward = dec_q.forward;
    assign dec_range   = dec_q.idx;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> dec_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !dec_valid);
    // R2
    fwd_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        dec_forward |-> dec_valid);
    // R6
    low_window_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit_vec[0]) |=> (dec_forward && dec_range == '0));
    // R5
    miss_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit_vec == '0) |=> !dec_forward);
    // R4
    claim_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_forward && dec_range == '0) |-> $past(win_q[0].enable));
endmodule

// File: tb/test_io_range_fwd.sv
module test_io_range_fwd;
    logic        clk = 1'b0;
    logic        rst;
    logic        alias_wr, alias_wdata, cfg_wr, cfg_sel, cfg_enable, req_valid;
    logic [15:0] cfg_lower, cfg_upper, req_addr;
    logic        dec_valid, dec_forward, dec_range;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    always #5 clk = ~clk;

    io_range_fwd i_io_range_fwd (
        .clk(clk), .rst(rst), .alias_wr(alias_wr), .alias_wdata(alias_wdata),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_lower(cfg_lower),
        .cfg_upper(cfg_upper), .cfg_enable(cfg_enable), .req_valid(req_valid),
        .req_addr(req_addr), .dec_valid(dec_valid), .dec_forward(dec_forward),
        .dec_range(dec_range)
    );

    task automatic check(string req, logic act_v, logic act_f, logic act_r,
                         logic exp_v, logic exp_f, logic exp_r);
        n_chk++;
        if (act_v !== exp_v || act_f !== exp_f || act_r !== exp_r) begin
            n_fail++;
            $display("FAIL %s: actual v=%b fwd=%b rng=%b expected v=%b fwd=%b rng=%b",
                     req, act_v, act_f, act_r, exp_v, exp_f, exp_r);
        end
    endtask

    task automatic set_win(logic sel, logic [15:0] lo, logic [15:0] hi, logic en);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = sel; cfg_lower = lo; cfg_upper = hi; cfg_enable = en;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic set_fold(logic on);
        @(negedge clk);
        alias_wr = 1; alias_wdata = on;
        @(negedge clk);
        alias_wr = 0;
    endtask

    // Issue one request; outputs are registered on the next edge and sampled at the negedge after it.
    task automatic probe(string req, logic [15:0] a, logic exp_f, logic exp_r);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        check(req, dec_valid, dec_forward, dec_range, 1'b1, exp_f, exp_r);
    endtask

    task automatic t_reset();
        rst = 1; alias_wr = 0; alias_wdata = 0; cfg_wr = 0; cfg_sel = 0;
        cfg_lower = 0; cfg_upper = 0; cfg_enable = 0; req_valid = 0; req_addr = 0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", dec_valid, dec_forward, dec_range, 0, 0, 0);
        rst = 0;
        probe("R1 windows off after reset", 16'h0000, 0, 0);
        probe("R1 fold off after reset", 16'h1310, 0, 0);
    endtask

    task automatic t_bounds();
        set_win(0, 16'h2000, 16'h20FF, 1);
        probe("R3 lower bound", 16'h2000, 1, 0);
        probe("R3 upper bound", 16'h20FF, 1, 0);
        probe("R3 inside", 16'h2080, 1, 0);
        probe("R5 below lower", 16'h1FFF, 0, 0);
        probe("R5 above upper", 16'h2100, 0, 0);
        set_win(1, 16'h8000, 16'h8003, 1);
        probe("R3 window 1 claims", 16'h8003, 1, 1);
        @(negedge clk);
        check("R2 idle after request", dec_valid, dec_forward, dec_range, 0, 0, 0);
    endtask

    task automatic t_disabled();
        set_win(1, 16'h8000, 16'h8003, 0);
        probe("R4 disabled window ignored", 16'h8001, 0, 0);
    endtask

    task automatic t_overlap();
        set_win(1, 16'h2080, 16'h2200, 1);
        probe("R6 overlap reports window 0", 16'h20A0, 1, 0);
        probe("R3 window 1 beyond window 0", 16'h2150, 1, 1);
    endtask

    task automatic t_inverted();
        set_win(1, 16'h0500, 16'h04FF, 1);
        probe("R11 inverted window at lower", 16'h0500, 0, 0);
        probe("R11 inverted window at upper", 16'h04FF, 0, 0);
    endtask

    task automatic t_fold();
        set_win(0, 16'h1000, 16'h10FF, 1);
        set_win(1, 16'h0300, 16'h031F, 1);
        set_fold(1);
        probe("R7 alias 1310h folds to 310h", 16'h1310, 1, 1);
        probe("R7 alias FD1Fh folds to 11Fh misses", 16'hFD1F, 0, 0);
        probe("R7 alias 7F00h folds to 300h", 16'h7F00, 1, 1);
        probe("R8 bits 9:8 zero stays 1010h", 16'h1010, 1, 0);
        probe("R8 upper bits zero stays 310h", 16'h0310, 1, 1);
        set_win(1, 16'h0040, 16'h005F, 1);
        probe("R8 below 100h unchanged", 16'h0050, 1, 1);
        set_win(1, 16'h0300, 16'h031F, 1);
        set_fold(0);
        probe("R9 fold off keeps 1310h", 16'h1310, 0, 0);
        probe("R9 fold off keeps 7F00h", 16'h7F00, 0, 0);
    endtask

    task automatic t_same_cycle();
        set_win(0, 16'h2000, 16'h20FF, 0);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = 0; cfg_lower = 16'h2000; cfg_upper = 16'h20FF; cfg_enable = 1;
        req_valid = 1; req_addr = 16'h2010;
        @(negedge clk);
        cfg_wr = 0; req_valid = 0;
        check("R10 same-cycle window write not yet applied", dec_valid, dec_forward, dec_range, 1, 0, 0);
        probe("R10 window write applied next request", 16'h2010, 1, 0);
        @(negedge clk);
        alias_wr = 1; alias_wdata = 1; req_valid = 1; req_addr = 16'h1310;
        @(negedge clk);
        alias_wr = 0; req_valid = 0;
        check("R10 same-cycle fold write not yet applied", dec_valid, dec_forward, dec_range, 1, 0, 0);
        probe("R10 fold write applied next request", 16'h1310, 1, 1);
    endtask

    initial begin
        t_reset();
        t_bounds();
        t_disabled();
        t_overlap();
        t_inverted();
        t_fold();
        t_same_cycle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule